// File: doc/BRIEF.md
# SONET Framing Word Aligner

This block sits behind a deserializer and receives parallel words cut at arbitrary bit positions from a SONET/SDH line. It searches every bit position of the incoming stream for a programmable 16-bit framing pattern. On the first occurrence it fixes a word boundary, then feeds every later word through a barrel shifter so that each output word begins on that boundary. The data width is 8, 16 or 32 bits, chosen by parameter.

Next to each output word the block drives two flags per byte lane. A pattern-detect flag marks a lane whose first bit starts a framing pattern. A sync-status flag says that the boundary has been confirmed by enough occurrences of the pattern at the same offset. A parameter can bit-reverse the configured pattern so that it suits a line sent most-significant bit first. Software or a higher-level framer can pulse a realign input to drop lock and restart the search.

Top module: `sonet_word_aligner`

## Requirements
- R1: Bit 0 of each input word is the earliest received bit, and bit i of the search pattern is compared with the i-th earliest bit of a candidate span. With FLIP_PAT=1 (the default) the search pattern is the bit reversal of FRAME_PAT (default 16'h146F), which gives 16'hF628. With FLIP_PAT=0 the search pattern is FRAME_PAT unchanged.
- R2: An occurrence is found at any bit offset, including spans that cross one or more input word boundaries.
- R3: The first occurrence found after reset or realign fixes the offset. If several offsets match in the same cycle, the lowest offset wins. Output words are then cut so that the pattern starts at bit 0 of dataOut.
- R4: Once an offset is fixed, occurrences at any other offset have no effect on the offset, the data or the sync flags until reset or realign.
- R5: Sync rises when LOCK_COUNT occurrences (default 2, counting the first) have been seen at the fixed offset. It rises on the output word that carries the last of them.
- R6: syncStat has one bit per byte lane, and all of its bits carry the same value. Once high, it stays high until reset or realign.
- R7: patDetect lane j is high when the search pattern begins at bit 8*j of that output word, measured at the current offset.
- R8: Data and flags have a fixed latency. With offset 0, a word driven before clock edge n appears on dataOut after edge n+2, and its flags appear in the same cycle.
- R9: When realignReq is sampled high, the output word produced at that edge has syncStat all zero and the fixed offset is released. Output keeps the old offset until a new occurrence is found.
- R10: While reset is held, dataOut, patDetect and syncStat are zero, the offset is 0 and no occurrence count is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| realignReq | input | 1 | Drop lock and restart the pattern search |
| dataIn | input | DATA_W | Unaligned parallel word, bit 0 earliest |
| dataOut | output | DATA_W | Word realigned to the framing boundary |
| patDetect | output | DATA_W/8 | Per-lane flag: pattern starts at this lane |
| syncStat | output | DATA_W/8 | Per-lane flag: boundary confirmed |

## Verification
Each result appears two clock edges after the input word it depends on. The same holds for the lock decision: a word that carries the confirming occurrence raises sync together with its own data two edges later, and realign clears sync in the word built at the edge where it is sampled. The bench drives inputs and compares outputs on the falling edge. It steps a behavioural model once per rising edge, so each prediction is compared one falling edge after the rising edge that produced it. Directed checks for lock, hold, realign and latency are timed by counting those same steps.

// File: rtl/sonet_align_pkg.sv
package sonet_align_pkg;

  localparam int PAT_W     = 16;
  // wide enough for any supported word width (up to 32 bit offsets)
  localparam int OFF_MAX_W = 5;

  // strobes from the lock control to the datapath
  typedef struct packed {
    logic [OFF_MAX_W-1:0] offSel;   // boundary used for this output word
    logic                 syncNow;  // sync state for this output word
  } alignCtrl_t;

  function automatic logic [PAT_W-1:0] revBits16(input logic [PAT_W-1:0] v);
    logic [PAT_W-1:0] r;
    for (int i = 0; i < PAT_W; i++) r[i] = v[PAT_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/sonet_align_datapath.sv
module sonet_align_datapath
  import sonet_align_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               LANES      = DATA_W / 8,
  parameter logic [PAT_W-1:0] SEARCH_PAT = 16'hF628
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  alignCtrl_t        ctrl,
  output logic [DATA_W-1:0] hitVec,
  output logic [DATA_W-1:0] dataOut,
  output logic [LANES-1:0]  patDetect,
  output logic [LANES-1:0]  syncStat
);

  // last offset + last lane start + pattern length
  localparam int SPAN   = 2 * DATA_W + 7;
  localparam int NWORDS = (SPAN + DATA_W - 1) / DATA_W;
  localparam int WIN_W  = NWORDS * DATA_W;
  localparam int IDX_W  = $clog2(WIN_W);

  logic [DATA_W-1:0] histQ [NWORDS-1];   // index 0 holds the oldest word
  logic [WIN_W-1:0]  window;
  logic [IDX_W-1:0]  offBase;
  logic [LANES-1:0]  laneHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS-1; i++) histQ[i] <= '0;
    end else begin
      for (int i = 0; i < NWORDS-2; i++) histQ[i] <= histQ[i+1];
      histQ[NWORDS-2] <= dataIn;
    end
  end

  always_comb begin
    window[WIN_W-1 -: DATA_W] = dataIn;
    for (int i = 0; i < NWORDS-1; i++) window[i*DATA_W +: DATA_W] = histQ[i];
  end

  // candidate starts inside the oldest word (R2: spans reach later words)
  for (genvar k = 0; k < DATA_W; k++) begin : g_hit
    assign hitVec[k] = (window[k +: PAT_W] == SEARCH_PAT);
  end

  assign offBase = IDX_W'(ctrl.offSel);

  // R7: a lane flag looks for the pattern at the lane's first bit
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDX_W-1:0] laneBase;
    assign laneBase   = offBase + IDX_W'(8 * j);
    assign laneHit[j] = (window[laneBase +: PAT_W] == SEARCH_PAT);
  end

  // R8: one register stage on the shifter output keeps data and flags together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      patDetect <= '0;
      syncStat  <= '0;
    end else begin
      dataOut   <= window[offBase +: DATA_W];
      patDetect <= laneHit;
      syncStat  <= {LANES{ctrl.syncNow}};
    end
  end

endmodule

// File: rtl/sonet_align_ctrl.sv
module sonet_align_ctrl
  import sonet_align_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LOCK_COUNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              realignReq,
  input  logic [DATA_W-1:0] hitVec,
  output alignCtrl_t        ctrl
);

  localparam int OFF_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(LOCK_COUNT + 1);

  logic [OFF_W-1:0] curOff, offNext, firstOff;
  logic [CNT_W-1:0] matchCnt, cntNext;
  logic             haveOff, haveNext, synced, syncNext, anyHit;

  // R3: lowest matching offset has priority
  always_comb begin
    firstOff = '0;
    for (int k = DATA_W-1; k >= 0; k--) begin
      if (hitVec[k]) firstOff = OFF_W'(k);
    end
  end

  assign anyHit = |hitVec;

  always_comb begin
    offNext  = curOff;
    haveNext = haveOff;
    cntNext  = matchCnt;
    syncNext = synced;
    if (realignReq) begin                       // R9
      haveNext = 1'b0;
      cntNext  = '0;
      syncNext = 1'b0;
    end else if (!haveOff) begin
      if (anyHit) begin                         // R3
        offNext  = firstOff;
        haveNext = 1'b1;
        cntNext  = CNT_W'(1);
        if (LOCK_COUNT <= 1) syncNext = 1'b1;
      end
    end else if (hitVec[curOff]) begin          // R4: other offsets ignored
      if (int'(matchCnt) < LOCK_COUNT) cntNext = matchCnt + 1'b1;
      if (int'(matchCnt) + 1 >= LOCK_COUNT) syncNext = 1'b1;  // R5
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curOff   <= '0;
      haveOff  <= 1'b0;
      matchCnt <= '0;
      synced   <= 1'b0;
    end else begin
      curOff   <= offNext;
      haveOff  <= haveNext;
      matchCnt <= cntNext;
      synced   <= syncNext;
    end
  end

  assign ctrl.offSel  = OFF_MAX_W'(offNext);
  assign ctrl.syncNow = syncNext;

endmodule

// File: rtl/sonet_word_aligner.sv
module sonet_word_aligner
  import sonet_align_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter int               LOCK_COUNT = 2,
  parameter logic [PAT_W-1:0] FRAME_PAT  = 16'h146F,
  parameter bit               FLIP_PAT   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  realignReq,
  input  logic [DATA_W-1:0]     dataIn,
  output logic [DATA_W-1:0]     dataOut,
  output logic [DATA_W/8-1:0]   patDetect,
  output logic [DATA_W/8-1:0]   syncStat
);

  localparam int               LANES      = DATA_W / 8;
  // R1: optional bit reversal for most-significant-first line order
  localparam logic [PAT_W-1:0] SEARCH_PAT = FLIP_PAT ? revBits16(FRAME_PAT) : FRAME_PAT;

  alignCtrl_t        ctrlBus;
  logic [DATA_W-1:0] hitVec;

  sonet_align_ctrl #(
    .DATA_W    (DATA_W),
    .LOCK_COUNT(LOCK_COUNT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .realignReq(realignReq),
    .hitVec    (hitVec),
    .ctrl      (ctrlBus)
  );

  sonet_align_datapath #(
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .SEARCH_PAT(SEARCH_PAT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .ctrl     (ctrlBus),
    .hitVec   (hitVec),
    .dataOut  (dataOut),
    .patDetect(patDetect),
    .syncStat (syncStat)
  );

endmodule

// File: rtl/sonet_word_aligner_sva.sv
module sonet_word_aligner_sva
  import sonet_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 realignReq,
  input logic [DATA_W/8-1:0]  patDetect,
  input logic [DATA_W/8-1:0]  syncStat,
  input logic [OFF_MAX_W-1:0] offSel
);

  localparam int LANES = DATA_W / 8;

  p_sync_lanes_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(syncStat) == 0) || ($countones(syncStat) == LANES));

  p_sync_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncStat[0]) |-> patDetect[0]);

  p_sync_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncStat[0]) |-> $past(realignReq));

  p_realign_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    realignReq |=> (syncStat == '0));

  p_hold_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (syncStat[0] && !realignReq) |-> $stable(offSel));

endmodule

bind sonet_word_aligner sonet_word_aligner_sva #(.DATA_W(DATA_W)) sva_i (
  .clk       (clk),
  .rstN      (rstN),
  .realignReq(realignReq),
  .patDetect (patDetect),
  .syncStat  (syncStat),
  .offSel    (ctrlBus.offSel)
);

// File: tb/sonet_word_aligner_tb_top.sv
module sonet_word_aligner_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN, realignReq;
  logic [31:0] din0, dout0;
  logic [3:0]  det0, sync0;
  logic [7:0]  din1, dout1;
  logic        det1, sync1;

  sonet_word_aligner dut_i (
    .clk(clk), .rstN(rstN), .realignReq(realignReq),
    .dataIn(din0), .dataOut(dout0), .patDetect(det0), .syncStat(sync0));

  sonet_word_aligner #(.DATA_W(8), .LOCK_COUNT(3), .FLIP_PAT(1'b0)) dut8_i (
    .clk(clk), .rstN(rstN), .realignReq(realignReq),
    .dataIn(din1), .dataOut(dout1), .patDetect(det1), .syncStat(sync1));

  int nChecks = 0;
  int nFails  = 0;

  // reference model state, unit 0 = 32-bit flipped, unit 1 = 8-bit plain
  int          widthU[2] = '{32, 8};
  int          lockU[2]  = '{2, 3};
  logic [15:0] patU[2]   = '{16'hF628, 16'h146F};   // R1
  logic [95:0] histU[2];
  int          offU[2], cntU[2];
  bit          haveU[2], syncU[2];
  logic [31:0] expData[2];
  logic [3:0]  expDet[2], expSync[2];
  bit          bq0[$];
  bit          bq1[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit hitAt(logic [95:0] w, int pos, logic [15:0] p);
    return 16'(w >> pos) == p;
  endfunction

  task automatic modelStep(input int u, input logic [31:0] din, input bit rl);
    int          w;
    logic [31:0] mask;
    logic [95:0] win;
    int          first;
    w     = widthU[u];
    mask  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    win   = histU[u] | ({64'd0, din & mask} << (2 * w));
    first = -1;
    if (rl) begin
      haveU[u] = 0; cntU[u] = 0; syncU[u] = 0;
    end else if (!haveU[u]) begin
      for (int k = w - 1; k >= 0; k--) if (hitAt(win, k, patU[u])) first = k;
      if (first >= 0) begin
        offU[u] = first; haveU[u] = 1; cntU[u] = 1;
        if (lockU[u] <= 1) syncU[u] = 1;
      end
    end else if (hitAt(win, offU[u], patU[u])) begin
      cntU[u]++;
      if (cntU[u] >= lockU[u]) syncU[u] = 1;
    end
    expData[u] = 32'(win >> offU[u]) & mask;
    expDet[u]  = '0;
    for (int j = 0; j < w / 8; j++) expDet[u][j] = hitAt(win, offU[u] + 8 * j, patU[u]);
    expSync[u] = syncU[u] ? 4'((1 << (w / 8)) - 1) : 4'd0;
    histU[u]   = (win >> w) & ((96'd1 << (2 * w)) - 1);
  endtask

  task automatic pushBit(input int u, input bit b);
    if (u == 0) bq0.push_back(b); else bq1.push_back(b);
  endtask

  task automatic pushZeros(input int u, input int n);
    for (int i = 0; i < n; i++) pushBit(u, 1'b0);
  endtask

  task automatic pushRand(input int u, input int n);
    for (int i = 0; i < n; i++) pushBit(u, 1'($urandom));
  endtask

  task automatic pushPat(input int u);
    for (int i = 0; i < 16; i++) pushBit(u, patU[u][i]);
  endtask

  task automatic pushWord(input int u, input logic [31:0] wd);
    for (int i = 0; i < widthU[u]; i++) pushBit(u, wd[i]);
  endtask

  task automatic pushFrames(input int u, input int lead, input int n, input int frameLen);
    pushZeros(u, lead);
    for (int f = 0; f < n; f++) begin
      pushPat(u);
      pushZeros(u, frameLen - 16);
    end
  endtask

  task automatic popWord(input int u, output logic [31:0] wd);
    wd = '0;
    for (int i = 0; i < widthU[u]; i++) begin
      bit b;
      b = 1'b0;
      if (u == 0) begin
        if (bq0.size() > 0) b = bq0.pop_front();
      end else begin
        if (bq1.size() > 0) b = bq1.pop_front();
      end
      wd[i] = b;
    end
  endtask

  task automatic compareAll();
    check("R8 dataOut w32", dout0, expData[0]);
    check("R7 patDetect w32", 32'(det0), 32'(expDet[0]));
    check("R5 syncStat w32", 32'(sync0), 32'(expSync[0]));
    check("R8 dataOut w8", 32'(dout1), expData[1]);
    check("R7 patDetect w8", 32'(det1), 32'(expDet[1][0]));
    check("R5 syncStat w8", 32'(sync1), 32'(expSync[1][0]));
    if (det0[0]) check("R1 R3 aligned pattern w32", 32'(dout0[15:0]), 32'(patU[0]));
    if (det1)    check("R1 R3 aligned pattern w8", 32'(dout1), 32'(patU[1][7:0]));
  endtask

  task automatic step(input bit rl);
    logic [31:0] w0, w1;
    @(negedge clk);
    compareAll();
    popWord(0, w0);
    popWord(1, w1);
    din0       = w0;
    din1       = w1[7:0];
    realignReq = rl;
    modelStep(0, w0, rl);
    modelStep(1, w1, rl);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  initial begin
    rstN = 1'b0; realignReq = 1'b0; din0 = '0; din1 = '0;
    for (int u = 0; u < 2; u++) begin
      histU[u] = '0; offU[u] = 0; cntU[u] = 0; haveU[u] = 0; syncU[u] = 0;
      expData[u] = '0; expDet[u] = '0; expSync[u] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset dataOut w32", dout0, 32'd0);
    check("R10 reset flags w32", {24'd0, det0, sync0}, 32'd0);
    check("R10 reset w8", {22'd0, dout1, det1, sync1}, 32'd0);
    rstN = 1'b1;
    modelStep(0, 32'd0, 1'b0);
    modelStep(1, 32'd0, 1'b0);

    // R8: offset 0 before any lock, word emerges two edges later
    pushWord(0, 32'hDEAD_BEEF);
    pushWord(1, 32'h3C);
    run(4);
    check("R8 latency w32", dout0, 32'hDEAD_BEEF);
    check("R8 latency w8", 32'(dout1), 32'h3C);

    // R2/R5: patterns crossing word boundaries, repeated at a fixed offset
    pushFrames(0, 27, 5, 128);
    pushFrames(1, 5, 5, 40);
    run(34);
    check("R5 R2 lock reached w32", 32'(sync0), 32'hF);
    check("R5 lock reached w8", 32'(sync1), 32'h1);

    // R4: patterns at a foreign offset leave lock and data cut untouched
    pushFrames(0, 3, 3, 128);
    pushFrames(1, 2, 3, 40);
    run(20);
    check("R4 lock held w32", 32'(sync0), 32'hF);
    check("R4 lock held w8", 32'(sync1), 32'h1);
    check("R6 all lanes agree w32", 32'($countones(sync0)), 32'd4);

    // R9: realign clears sync on the next output word
    step(1'b1);
    step(1'b0);
    check("R9 sync cleared w32", 32'(sync0), 32'h0);
    check("R9 sync cleared w8", 32'(sync1), 32'h0);

    // R3: two patterns in one word, lowest offset (4) must win
    pushZeros(0, 4);
    pushPat(0);
    pushPat(0);
    pushFrames(0, 96, 3, 128);
    pushFrames(1, 6, 4, 40);
    run(30);
    check("R3 lowest offset locks w32", 32'(sync0), 32'hF);
    check("R9 relock w8", 32'(sync1), 32'h1);

    // random traffic after another realign
    step(1'b1);
    pushRand(0, 32 * 150);
    pushRand(1, 8 * 150);
    run(152);
    step(1'b0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule